// File: doc/BRIEF.md
# Compare-Output Timer

A timer built around a single counter that several compare channels share. The counter advances on a clock enable and has four count modes: stopped, up to a period value with a wrap to zero, free-running through its whole range, or up to the period value and then back down to zero. Each channel holds a compare value and a three-bit output mode. On each counting step the channel checks for two events. The first is a match between its own compare value and the counter. The second is the counter's period event. The mode decides what each event does to the channel's output pin.

The eight output modes are direct drive, set, toggle/reset, set/reset, toggle, reset, toggle/set and reset/set. They can produce a single edge, a square wave at half the toggle rate, edge-aligned PWM in up mode, or center-aligned PWM in up/down mode. One channel can give either PWM shape; only the count mode changes.

Software configures the block through a plain register write port. The only outputs are the pins. No data stream passes through the block, so there is no valid/ready handshake at its edge.

Top module: `cmp_timer`

## Requirements
- R1: After reset all output pins are 0, the counter holds 0 and is stopped, and every channel is in output mode 0.
- R2: Writes use wr_addr and wr_data, and a written value is used from the next clock. The addresses are as follows. Address 0 is count control: bits [1:0] select the count mode (0 stop, 1 up, 2 continuous, 3 up/down), and any write here restarts the counter at 0 with the count direction set to up. Address 1 holds the period value. Address 2+2k is the control of channel k: bits [2:0] hold the output mode and bit 3 holds the direct level. Address 3+2k holds the compare value of channel k.
- R3: In up mode the counter steps 0,1,…,P and then returns to 0, where P is the period value. The period event fires while the counter equals P.
- R4: In continuous mode the counter steps through the full range and wraps from all-ones to 0. The period event fires while the counter equals 0.
- R5: In up/down mode the counter climbs from 0 to P and then falls back to 0, and this repeats. The period event fires at P. A compare value strictly between 0 and P matches once on the way up and once on the way down.
- R6: The counter and the pins change only on a clock where tick is 1 and the count mode is not stop. A pin takes its new level on the clock edge that ends the tick cycle in which the counter held the matching value. Otherwise each pin holds its level.
- R7: In mode 0 a pin takes the direct level written in bit 3, on the clock after the write. All compare and period events are ignored in this mode.
- R8: Mode 4 inverts the pin at every channel match.
- R9: Mode 1 sets the pin at a channel match and mode 5 clears it. Both ignore the period event.
- R10: Mode 3 sets the pin at a channel match and clears it at the period event. Mode 7 clears it at a channel match and sets it at the period event. In up mode both give edge-aligned PWM.
- R11: Mode 2 toggles the pin at a channel match and clears it at the period event. Mode 6 toggles it at a channel match and sets it at the period event. In up/down mode both give center-aligned PWM.
- R12: When a channel match and the period event happen in the same step, the period action decides the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable; one counting step per clock where it is high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address (ADDR_W = clog2(2+2*NUM_CH)) |
| wr_data | input | CNT_W | Register write data |
| out_pin | output | NUM_CH | Channel output pins |

## Verification
The bench runs the counter with the period value at 0, at small values and across the full continuous wrap. These runs catch a wrap that is one count early or late, and an up/down turn that repeats the top or bottom value; either fault would shift every later PWM edge. A compare value equal to the period value, and a compare value of 0 in continuous mode, make the two events coincide. A design that let the channel action win there would leave a pin toggled or set where it should have been cleared. The bench gates tick at random and writes mode 0 over active channels, so a pin that moved without a tick or reacted to events in direct mode shows up as a mismatch with the model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    CM_STOP = 2'd0,
    CM_UP   = 2'd1,
    CM_CONT = 2'd2,
    CM_UPDN = 2'd3
  } cmode_e;

  typedef enum logic [2:0] {
    OM_DIRECT  = 3'd0,
    OM_SET     = 3'd1,
    OM_TGL_RST = 3'd2,
    OM_SET_RST = 3'd3,
    OM_TGL     = 3'd4,
    OM_RST     = 3'd5,
    OM_TGL_SET = 3'd6,
    OM_RST_SET = 3'd7
  } omode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_INV  = 2'd3
  } act_e;

  function automatic act_e match_act(omode_e m);
    case (m)
      OM_SET, OM_SET_RST:             return ACT_SET;
      OM_RST, OM_RST_SET:             return ACT_CLR;
      OM_TGL, OM_TGL_RST, OM_TGL_SET: return ACT_INV;
      default:                        return ACT_NONE;
    endcase
  endfunction

  function automatic act_e period_act(omode_e m);
    case (m)
      OM_TGL_RST, OM_SET_RST: return ACT_CLR;
      OM_TGL_SET, OM_RST_SET: return ACT_SET;
      default:                return ACT_NONE;
    endcase
  endfunction

  function automatic logic apply_act(act_e a, logic cur);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_INV: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [CNT_W-1:0]                wr_data,
  output cmode_e                          cmode,
  output logic [CNT_W-1:0]                period,
  output logic                            restart,
  output logic [NUM_CH-1:0][2:0]          ch_mode,
  output logic [NUM_CH-1:0][CNT_W-1:0]    ch_cmp,
  output logic [NUM_CH-1:0]               ch_load,
  output logic                            load_val
);

  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(1);

  assign restart  = wr_en && (wr_addr == A_CTL);
  assign load_val = wr_data[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmode  <= CM_STOP;
      period <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTL) cmode  <= cmode_e'(wr_data[1:0]);
      if (wr_addr == A_PER) period <= wr_data;
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CCTL = ADDR_W'(2 + 2 * k);
    localparam logic [ADDR_W-1:0] A_CCMP = ADDR_W'(3 + 2 * k);

    logic ctl_hit;
    assign ctl_hit    = wr_en && (wr_addr == A_CCTL);
    assign ch_load[k] = ctl_hit && (wr_data[2:0] == 3'd0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_mode[k] <= 3'd0;
        ch_cmp[k]  <= '0;
      end else begin
        if (ctl_hit) ch_mode[k] <= wr_data[2:0];
        if (wr_en && (wr_addr == A_CCMP)) ch_cmp[k] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cmode_e           cmode,
  input  logic [CNT_W-1:0] period,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             step,
  output logic             per_evt
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic dir_dn;

  assign step = tick && (cmode != CM_STOP);

  always_comb begin
    case (cmode)
      CM_UP, CM_UPDN: per_evt = step && (cnt == period);
      CM_CONT:        per_evt = step && (cnt == ZERO);
      default:        per_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= ZERO;
      dir_dn <= 1'b0;
    end else if (restart) begin
      cnt    <= ZERO;
      dir_dn <= 1'b0;
    end else if (step) begin
      case (cmode)
        CM_UP:   cnt <= (cnt >= period) ? ZERO : cnt + ONE;
        CM_CONT: cnt <= cnt + ONE;
        CM_UPDN: begin
          if (period == ZERO) begin
            cnt <= ZERO;
          end else if (!dir_dn) begin
            if (cnt >= period) begin
              dir_dn <= 1'b1;
              cnt    <= cnt - ONE;
            end else begin
              cnt <= cnt + ONE;
            end
          end else if (cnt == ZERO) begin
            dir_dn <= 1'b0;
            cnt    <= ONE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: cnt <= cnt;
      endcase
    end
  end

  p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmode == CM_UP && step && cnt == period) |=> (cnt == ZERO));

  p_cont_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmode == CM_CONT && step && !restart) |=> (cnt == CNT_W'($past(cnt) + ONE)));

  p_updn_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmode == CM_UPDN && step && !restart && period != ZERO && cnt == period && !dir_dn)
    |=> (cnt == CNT_W'($past(cnt) - ONE)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(cnt));

endmodule

// File: rtl/tmr_outunit.sv
module tmr_outunit
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             per_evt,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [2:0]       mode,
  input  logic             load,
  input  logic             load_val,
  output logic             pin
);

  omode_e om;
  logic   hit;
  logic   after_match;
  logic   nxt;

  assign om  = omode_e'(mode);
  assign hit = step && (cnt == cmp);

  always_comb begin
    after_match = hit ? apply_act(match_act(om), pin) : pin;
    nxt         = per_evt ? apply_act(period_act(om), after_match) : after_match;
    if (om == OM_DIRECT) nxt = pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pin <= 1'b0;
    else if (load) pin <= load_val;
    else           pin <= nxt;
  end

  p_direct_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (om == OM_DIRECT && !load) |=> $stable(pin));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(pin));

  p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (om == OM_TGL && hit && !load) |=> (pin != $past(pin)));

  p_period_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((om == OM_SET_RST || om == OM_TGL_RST) && per_evt && !load) |=> !pin);

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  localparam int ADDR_W = $clog2(2 + 2 * NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NUM_CH-1:0] out_pin
);

  cmode_e                       cmode;
  logic [CNT_W-1:0]             period;
  logic                         restart;
  logic [NUM_CH-1:0][2:0]       ch_mode;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_cmp;
  logic [NUM_CH-1:0]            ch_load;
  logic                         load_val;
  logic [CNT_W-1:0]             cnt;
  logic                         step;
  logic                         per_evt;

  tmr_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cmode    (cmode),
    .period   (period),
    .restart  (restart),
    .ch_mode  (ch_mode),
    .ch_cmp   (ch_cmp),
    .ch_load  (ch_load),
    .load_val (load_val)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cmode   (cmode),
    .period  (period),
    .restart (restart),
    .cnt     (cnt),
    .step    (step),
    .per_evt (per_evt)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_out
    tmr_outunit #(.CNT_W(CNT_W)) u_ou (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .per_evt  (per_evt),
      .cnt      (cnt),
      .cmp      (ch_cmp[k]),
      .mode     (ch_mode[k]),
      .load     (ch_load[k]),
      .load_val (load_val),
      .pin      (out_pin[k])
    );
  end

endmodule

// File: tb/cmp_timer_bench.sv
`timescale 1ns/1ps
module cmp_timer_bench;
  localparam int CW  = 16;
  localparam int NC  = 2;
  localparam int AW  = $clog2(2 + 2 * NC);
  localparam int MAXV = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NC-1:0] out_pin;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";
  bit    done = 0;
  int    lfsr = 32'h1d2c;

  always #2 clk = ~clk;

  cmp_timer u_cmp_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_pin(out_pin)
  );

  // Behavioural reference model
  int m_cnt, m_dir, m_cm, m_per;
  int m_mode[NC];
  int m_cmp[NC];
  bit m_out[NC];

  always @(posedge clk) begin : model
    bit run, pe, ce;
    int nc, ch;
    if (!rst_n) begin
      m_cnt = 0; m_dir = 0; m_cm = 0; m_per = 0;
      for (int i = 0; i < NC; i++) begin m_mode[i] = 0; m_cmp[i] = 0; m_out[i] = 0; end
    end else begin
      run = tick && (m_cm != 0);
      pe  = run && ((m_cm == 2) ? (m_cnt == 0) : (m_cnt == m_per));
      for (int i = 0; i < NC; i++) begin
        ce = run && (m_cnt == m_cmp[i]);
        if (m_mode[i] != 0) begin
          if (ce) begin
            if (m_mode[i] == 1 || m_mode[i] == 3) m_out[i] = 1;
            else if (m_mode[i] == 5 || m_mode[i] == 7) m_out[i] = 0;
            else m_out[i] = !m_out[i];
          end
          if (pe) begin
            if (m_mode[i] == 2 || m_mode[i] == 3) m_out[i] = 0;
            else if (m_mode[i] == 6 || m_mode[i] == 7) m_out[i] = 1;
          end
        end
      end
      nc = m_cnt;
      if (run) begin
        if (m_cm == 1) nc = (m_cnt >= m_per) ? 0 : m_cnt + 1;
        else if (m_cm == 2) nc = (m_cnt + 1) % MAXV;
        else if (m_per == 0) nc = 0;
        else if (m_dir == 0) begin
          if (m_cnt >= m_per) begin m_dir = 1; nc = m_cnt - 1; end
          else nc = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_dir = 0; nc = 1; end
          else nc = m_cnt - 1;
        end
      end
      m_cnt = nc;
      if (wr_en) begin
        if (wr_addr == 0) begin m_cm = int'(wr_data[1:0]); m_cnt = 0; m_dir = 0; end
        else if (wr_addr == 1) m_per = int'(wr_data);
        else if (int'(wr_addr) < 2 + 2 * NC) begin
          ch = (int'(wr_addr) - 2) / 2;
          if (wr_addr[0] == 1'b0) begin
            m_mode[ch] = int'(wr_data[2:0]);
            if (wr_data[2:0] == 3'd0) m_out[ch] = wr_data[3];
          end else m_cmp[ch] = int'(wr_data);
        end
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
    if (rst_n) begin
      for (int i = 0; i < NC; i++) begin
        n_chk++;
        if (out_pin[i] !== m_out[i]) begin
          n_err++;
          $display("FAIL %s: ch%0d pin=%b expected=%b at %0t", cur_req, i, out_pin[i], m_out[i], $time);
        end
      end
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, input bit rnd);
    for (int i = 0; i < n; i++) begin
      if (rnd) begin
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
        tick = lfsr[0];
      end else tick = 1'b1;
      cyc();
    end
    tick = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    n_err++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    run(4, 1'b1);

    cur_req = "R7 direct level";
    wr(2, 8); wr(4, 0); cyc();
    wr(0, 1); wr(1, 3); wr(3, 1); run(12, 1'b0);
    wr(2, 0); run(6, 1'b0);

    cur_req = "R10/R3 edge PWM up";
    wr(1, 9); wr(3, 3); wr(5, 6);
    wr(2, 7); wr(4, 3); wr(0, 1);
    run(45, 1'b0);

    cur_req = "R6 gated tick";
    run(80, 1'b1);

    cur_req = "R2 restart";
    run(4, 1'b0); wr(0, 1); run(15, 1'b0);

    cur_req = "R8 toggle in up";
    wr(2, 4); wr(4, 4); wr(5, 0); run(30, 1'b0);

    cur_req = "R3 period zero";
    wr(1, 0); wr(3, 0); run(8, 1'b0);

    cur_req = "R12 coincidence";
    wr(2, 8); wr(4, 0); wr(1, 5); wr(3, 5); wr(5, 5);
    wr(2, 3); wr(4, 6); wr(0, 1); run(20, 1'b0);
    wr(2, 7); wr(4, 2); run(20, 1'b0);

    cur_req = "R11/R5 center PWM";
    wr(1, 8); wr(3, 3); wr(5, 5);
    wr(2, 2); wr(4, 6); wr(0, 3);
    run(60, 1'b0);
    run(40, 1'b1);
    wr(1, 1); wr(3, 1); wr(5, 0); wr(0, 3); run(12, 1'b0);

    cur_req = "R4/R9/R8 continuous";
    wr(3, 100); wr(5, 5000);
    wr(2, 4); wr(4, 1); wr(0, 2);
    run(20000, 1'b0);
    wr(4, 5); run(MAXV - 20000 + 300, 1'b0);

    cur_req = "R12 zero coincidence";
    wr(3, 0); wr(2, 7); wr(5, 0); wr(4, 1); wr(0, 2);
    run(MAXV + 20, 1'b0);

    cur_req = "R7 ignore events";
    wr(2, 0); wr(4, 8); run(40, 1'b0);

    finish_up();
  end

endmodule